// File: doc/BRIEF.md
# Real-Time Counter with Compare and Periodic Interrupts

This block keeps a free-running up-counter and raises two kinds of interrupt. The first comes from a compare: the upper 12 bits of the counter are matched against a programmed value, and a wrap of the counter can optionally raise the same event. The second comes from a separate periodic timer, which reloads every time it reaches its own 10-bit period. Both are programmed through one 32-bit control word. The whole block runs on a single system clock. The count advances on clock-enable pulses taken from one of four source inputs, and each pulse can pass through an optional divide-by-512 stage and an optional divide-by-32 stage.

The run bit in the control word also serves as the reset of all timer state. While it is low, the counter, the prescalers, the periodic timer and both flags are held at zero. Clock source, prescaler and compare settings can only be loaded in that state. While the run bit is high, those fields ignore writes, so a running timer never sees a half-applied setting. A freeze bit lets a debug-halt input stop all counting, and counting continues from the held value once the halt is released. Each flag is cleared by a one-cycle clear pulse on its own input.

Top module: `rtc_api_timer`

## Requirements
- R1: After rst_ni is released, rd_data_o, cnt_o, flags_o, cmp_irq_o and api_irq_o are all zero.
- R2: While the run bit (bit 31) is 0, the counter, both prescaler stages, the periodic timer and both flags stay at zero. Counting starts with the first tick after the run bit is written to 1.
- R3: The counter goes up by exactly one for each tick that leaves the prescaler chain.
- R4: Flag bit 0 of flags_o sets on the tick that makes the counter's upper 12 bits equal the compare value (bits 27:16) while every lower bit is zero. A compare value of 0 never sets it this way.
- R5: While the run bit is 1, a write updates only bits 31:28 and 15:14. Bits 27:16, 13:10 and 9:0 keep their old values. While the run bit is 0, a write loads all 32 bits. rd_data_o always returns the stored word.
- R6: cmp_irq_o is high exactly when flag bit 0 and the compare interrupt enable (bit 30) are both 1. api_irq_o is high exactly when flag bit 1 and the periodic interrupt enable (bit 14) are both 1. A flag can set while its enable is 0.
- R7: A one-cycle pulse on cmp_clr_i or api_clr_i clears the matching flag. If a set and a clear fall in the same cycle, the flag stays set.
- R8: With freeze enable (bit 29) at 1 and dbg_halt_i high, the counter, the prescalers and the periodic timer hold their values, and counting resumes from those values once the halt is released. With bit 29 at 0, dbg_halt_i has no effect.
- R9: The source select field (bits 13:12) with value n takes its ticks from clk_en_i[n] and ignores the other enable inputs.
- R10: Bit 11 puts a divide-by-512 stage in the tick path and bit 10 puts a divide-by-32 stage in it. With both stages on, the division is 16384.
- R11: With the periodic enable (bit 15) at 1 and a nonzero period P in bits 9:0, flag bit 1 sets on every P-th tick. A period of 0 produces no events.
- R12: With the wrap enable (bit 28) at 1, flag bit 0 also sets on the tick that takes the counter from all ones to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Write strobe for the control word |
| wr_data_i | input | 32 | Control word to write |
| rd_data_o | output | 32 | Stored control word |
| clk_en_i | input | 4 | Tick sources, one of which the select field picks |
| dbg_halt_i | input | 1 | Debug halt request |
| cmp_clr_i | input | 1 | Clear pulse for the compare flag |
| api_clr_i | input | 1 | Clear pulse for the periodic flag |
| cnt_o | output | CNT_W | Current counter value |
| flags_o | output | 2 | Bit 0: compare flag; bit 1: periodic flag |
| cmp_irq_o | output | 1 | Compare interrupt request |
| api_irq_o | output | 1 | Periodic interrupt request |

## Verification
The assertions check on every cycle the following properties:
- A running timer ignores writes to its locked fields.
- A halted and frozen counter holds still.
- A cleared run bit leaves the counter and flags at zero.
- A set wins over a simultaneous clear.
- A prescaler never emits a tick that it did not receive.
- The periodic counter stays below its period.

Only the bench scenarios can show the exact cycle on which each event happens: the compare match, the wrap at all ones, every P-th periodic tick, and the division ratios of 512, 32 and 16384. The same applies to source selection, interrupt masking, and counting resuming from the held value after a halt.

// File: rtl/rtc_api_pkg.sv
package rtc_api_pkg;
  localparam int CMP_W = 12;
  localparam int API_W = 10;
  localparam int SEL_W = 2;
  localparam int N_SRC = 1 << SEL_W;
  localparam int N_DIV = 2;

  typedef struct packed {
    logic             run;
    logic             cmp_ie;
    logic             frz_en;
    logic             wrap_en;
    logic [CMP_W-1:0] cmp_val;
    logic             api_run;
    logic             api_ie;
    logic [SEL_W-1:0] src_sel;
    logic             div512_en;
    logic             div32_en;
    logic [API_W-1:0] api_val;
  } ctrl_t;

  // stage 0 divides by 512, stage 1 by 32
  function automatic int div_log2(input int idx);
    return (idx == 0) ? 9 : 5;
  endfunction
endpackage

// File: rtl/rtc_ctrl_reg.sv
module rtc_ctrl_reg
  import rtc_api_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_en_i,
  input  logic [31:0] wr_data_i,
  output ctrl_t       ctrl_o
);
  ctrl_t ctrl_q, ctrl_d, wd;

  assign wd = ctrl_t'(wr_data_i);

  always_comb begin
    ctrl_d = ctrl_q;
    if (wr_en_i) begin
      if (ctrl_q.run) begin
        // live fields only; timing setup is locked while running
        ctrl_d.run     = wd.run;
        ctrl_d.cmp_ie  = wd.cmp_ie;
        ctrl_d.frz_en  = wd.frz_en;
        ctrl_d.wrap_en = wd.wrap_en;
        ctrl_d.api_run = wd.api_run;
        ctrl_d.api_ie  = wd.api_ie;
      end else begin
        ctrl_d = wd;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ctrl_q <= '0;
    else         ctrl_q <= ctrl_d;
  end

  assign ctrl_o = ctrl_q;

  assert_locked_fields_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_q.run && wr_en_i) |=> ($stable(ctrl_q.cmp_val) && $stable(ctrl_q.src_sel) &&
                                 $stable(ctrl_q.div512_en) && $stable(ctrl_q.div32_en) &&
                                 $stable(ctrl_q.api_val)));
endmodule

// File: rtl/rtc_div_stage.sv
module rtc_div_stage #(
  parameter int DIV_LOG2 = 5
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic tick_i,
  output logic tick_o
);
  logic [DIV_LOG2-1:0] cnt_q;

  assign tick_o = en_i ? (tick_i && (&cnt_q)) : tick_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (en_i && tick_i)  cnt_q <= cnt_q + 1'b1;
  end

  assert_div_no_spurious_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |-> tick_i);
endmodule

// File: rtl/rtc_main_cnt.sv
module rtc_main_cnt #(
  parameter int CNT_W = 32,
  parameter int CMP_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic [CMP_W-1:0] cmp_val_i,
  input  logic             wrap_en_i,
  input  logic             clr_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             flag_o
);
  localparam int LOW_W = CNT_W - CMP_W;

  logic [CNT_W-1:0] cnt_q, cnt_nx;
  logic             flag_q, hit, wrap, set;

  assign cnt_nx = cnt_q + 1'b1;
  assign hit    = (cmp_val_i != '0) && (cnt_nx[CNT_W-1 -: CMP_W] == cmp_val_i)
                  && (cnt_nx[LOW_W-1:0] == '0);
  assign wrap   = wrap_en_i && (&cnt_q);
  assign set    = tick_i && (hit || wrap);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      if (tick_i) cnt_q <= cnt_nx;
      if (set)        flag_q <= 1'b1;
      else if (clr_i) flag_q <= 1'b0;
    end
  end

  assign cnt_o  = cnt_q;
  assign flag_o = flag_q;

  assert_cmp_set_wins_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set && clr_i) |=> flag_q);
  assert_cmp_zero_quiet_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmp_val_i == '0 && !wrap_en_i && !flag_q) |=> !flag_q);
endmodule

// File: rtl/rtc_api_cnt.sv
module rtc_api_cnt #(
  parameter int API_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             tick_i,
  input  logic [API_W-1:0] period_i,
  input  logic             clr_i,
  output logic             flag_o
);
  logic [API_W-1:0] cnt_q, cnt_nx;
  logic             flag_q, step, set;

  assign cnt_nx = cnt_q + 1'b1;
  assign step   = run_i && tick_i && (period_i != '0);
  assign set    = step && (cnt_nx == period_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      if (step) cnt_q <= set ? '0 : cnt_nx;
      if (set)        flag_q <= 1'b1;
      else if (clr_i) flag_q <= 1'b0;
    end
  end

  assign flag_o = flag_q;

  assert_api_below_period_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (period_i != '0) |-> (cnt_q < period_i));
  assert_api_set_wins_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set && clr_i) |=> flag_q);
  assert_api_zero_quiet_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (period_i == '0 && !flag_q) |=> !flag_q);
endmodule

// File: rtl/rtc_api_timer.sv
module rtc_api_timer
  import rtc_api_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [31:0]      wr_data_i,
  output logic [31:0]      rd_data_o,
  input  logic [N_SRC-1:0] clk_en_i,
  input  logic             dbg_halt_i,
  input  logic             cmp_clr_i,
  input  logic             api_clr_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [1:0]       flags_o,
  output logic             cmp_irq_o,
  output logic             api_irq_o
);
  ctrl_t            ctrl;
  logic             tmr_rst_n, frozen, src_tick;
  logic [N_DIV:0]   tk;
  logic [N_DIV-1:0] div_en;
  logic             cmp_flag, api_flag;

  rtc_ctrl_reg u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_data_i (wr_data_i),
    .ctrl_o    (ctrl)
  );

  // run bit low resets timer state asynchronously; release follows the registered bit
  assign tmr_rst_n = rst_ni && ctrl.run;
  assign frozen    = ctrl.frz_en && dbg_halt_i;
  assign src_tick  = clk_en_i[ctrl.src_sel];
  assign tk[0]     = src_tick && !frozen;
  assign div_en    = {ctrl.div32_en, ctrl.div512_en};

  for (genvar g = 0; g < N_DIV; g++) begin : g_div
    rtc_div_stage #(.DIV_LOG2(div_log2(g))) u_div (
      .clk_i  (clk_i),
      .rst_ni (tmr_rst_n),
      .en_i   (div_en[g]),
      .tick_i (tk[g]),
      .tick_o (tk[g+1])
    );
  end

  rtc_main_cnt #(.CNT_W(CNT_W), .CMP_W(CMP_W)) u_main (
    .clk_i     (clk_i),
    .rst_ni    (tmr_rst_n),
    .tick_i    (tk[N_DIV]),
    .cmp_val_i (ctrl.cmp_val),
    .wrap_en_i (ctrl.wrap_en),
    .clr_i     (cmp_clr_i),
    .cnt_o     (cnt_o),
    .flag_o    (cmp_flag)
  );

  rtc_api_cnt #(.API_W(API_W)) u_api (
    .clk_i    (clk_i),
    .rst_ni   (tmr_rst_n),
    .run_i    (ctrl.api_run),
    .tick_i   (tk[N_DIV]),
    .period_i (ctrl.api_val),
    .clr_i    (api_clr_i),
    .flag_o   (api_flag)
  );

  assign rd_data_o = ctrl;
  assign flags_o   = {api_flag, cmp_flag};
  assign cmp_irq_o = cmp_flag && ctrl.cmp_ie;
  assign api_irq_o = api_flag && ctrl.api_ie;

  assert_freeze_hold_R8: assert property (@(posedge clk_i) disable iff (!tmr_rst_n)
    frozen |=> $stable(cnt_o));
  assert_stopped_clear_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl.run |-> (cnt_o == '0 && flags_o == 2'b00));
endmodule

// File: tb/rtc_api_timer_bench.sv
module rtc_api_timer_bench;
  localparam int CW = 16;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          wr_en = 1'b0;
  logic [31:0]   wr_data = '0;
  logic [31:0]   rd_data;
  logic [3:0]    clk_en = 4'b0001;
  logic          dbg_halt = 1'b0;
  logic          cmp_clr = 1'b0;
  logic          api_clr = 1'b0;
  logic [CW-1:0] cnt;
  logic [1:0]    flags;
  logic          cmp_irq, api_irq;

  always #2.5 clk = ~clk;

  rtc_api_timer #(.CNT_W(CW)) u_rtc_api_timer (
    .clk_i      (clk),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en),
    .wr_data_i  (wr_data),
    .rd_data_o  (rd_data),
    .clk_en_i   (clk_en),
    .dbg_halt_i (dbg_halt),
    .cmp_clr_i  (cmp_clr),
    .api_clr_i  (api_clr),
    .cnt_o      (cnt),
    .flags_o    (flags),
    .cmp_irq_o  (cmp_irq),
    .api_irq_o  (api_irq)
  );

  typedef struct {
    int          kind;   // 0 cnt, 1 rd_data, 2 flags, 3 {api_irq,cmp_irq}
    logic [31:0] exp;
    string       req;
  } item_t;

  item_t q[$];
  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  // monitor: compares queued expectations against the ports
  always @(negedge clk) begin
    while (q.size() > 0) begin
      item_t it;
      logic [31:0] act;
      it  = q.pop_front();
      act = '0;
      case (it.kind)
        0: act[CW-1:0] = cnt;
        1: act = rd_data;
        2: act[1:0] = flags;
        default: act[1:0] = {api_irq, cmp_irq};
      endcase
      n_chk++;
      if (act !== it.exp) begin
        n_bad++;
        $display("FAIL %s kind=%0d actual=%h expected=%h", it.req, it.kind, act, it.exp);
      end
    end
  end

  task automatic expect_item(input int kind, input logic [31:0] e, input string r);
    item_t it;
    it.kind = kind;
    it.exp  = e;
    it.req  = r;
    q.push_back(it);
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [31:0] d);
    wr_en = 1'b1;
    wr_data = d;
    step(1);
    wr_en = 1'b0;
  endtask

  function automatic logic [31:0] mk(input bit run, input bit cie, input bit frz, input bit wen,
                                     input logic [11:0] cval, input bit arun, input bit aie,
                                     input logic [1:0] sel, input bit d512, input bit d32,
                                     input logic [9:0] aval);
    return {run, cie, frz, wen, cval, arun, aie, sel, d512, d32, aval};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] c0;
    repeat (3) @(posedge clk);
    #1 rst_ni = 1'b1;
    step(1);
    expect_item(1, 32'h0, "R1 ctrl");
    expect_item(0, 32'h0, "R1 cnt");
    expect_item(2, 32'h0, "R1 flags");
    expect_item(3, 32'h0, "R1 irq");
    step(1);

    // compare event at count 3*16 with CNT_W=16
    wr(mk(1, 1, 0, 0, 12'd3, 0, 0, 2'd0, 0, 0, 10'd0));
    expect_item(0, 32'd0, "R2 start");
    step(10);
    expect_item(0, 32'd10, "R3 count");
    step(37);
    expect_item(0, 32'd47, "R3 count");
    expect_item(2, 32'd0, "R4 before match");
    step(1);
    expect_item(0, 32'd48, "R3 count");
    expect_item(2, 32'b01, "R4 match");
    expect_item(3, 32'b01, "R6 cmp irq");
    cmp_clr = 1'b1;
    step(1);
    cmp_clr = 1'b0;
    expect_item(2, 32'b00, "R7 clear");

    // locked fields while running
    wr(mk(1, 0, 0, 0, 12'd5, 0, 0, 2'd1, 0, 1, 10'd7));
    expect_item(1, mk(1, 0, 0, 0, 12'd3, 0, 0, 2'd0, 0, 0, 10'd0), "R5 lock");

    // freeze
    wr(mk(1, 0, 1, 0, 12'd3, 0, 0, 2'd0, 0, 0, 10'd0));
    c0 = 32'(cnt);
    dbg_halt = 1'b1;
    step(5);
    expect_item(0, c0, "R8 frozen");
    dbg_halt = 1'b0;
    step(3);
    expect_item(0, c0 + 3, "R8 resume");
    wr(mk(1, 0, 0, 0, 12'd3, 0, 0, 2'd0, 0, 0, 10'd0));
    c0 = 32'(cnt);
    dbg_halt = 1'b1;
    step(4);
    expect_item(0, c0 + 4, "R8 no freeze");
    dbg_halt = 1'b0;

    // stop resets timer state
    wr(32'h0);
    expect_item(0, 32'd0, "R2 stop");
    step(3);
    expect_item(0, 32'd0, "R2 held");

    // set beats clear, flag sets with irq masked
    wr(mk(1, 0, 0, 0, 12'd1, 0, 0, 2'd0, 0, 0, 10'd0));
    step(15);
    expect_item(0, 32'd15, "R3 count");
    cmp_clr = 1'b1;
    step(1);
    cmp_clr = 1'b0;
    expect_item(2, 32'b01, "R7 set wins");
    expect_item(3, 32'b00, "R6 masked");

    // zero compare value
    wr(32'h0);
    wr(mk(1, 1, 0, 0, 12'd0, 0, 0, 2'd0, 0, 0, 10'd0));
    step(40);
    expect_item(2, 32'b00, "R4 zero compare");

    // source select
    wr(32'h0);
    wr(mk(1, 0, 0, 0, 12'd0, 0, 0, 2'd2, 0, 0, 10'd0));
    step(10);
    expect_item(0, 32'd0, "R9 other source");
    clk_en = 4'b0100;
    step(10);
    expect_item(0, 32'd10, "R9 selected source");
    clk_en = 4'b0001;

    // prescalers
    wr(32'h0);
    wr(mk(1, 0, 0, 0, 12'd0, 0, 0, 2'd0, 0, 1, 10'd0));
    step(95);
    expect_item(0, 32'd2, "R10 div32");
    step(1);
    expect_item(0, 32'd3, "R10 div32");
    wr(32'h0);
    wr(mk(1, 0, 0, 0, 12'd0, 0, 0, 2'd0, 1, 0, 10'd0));
    step(1023);
    expect_item(0, 32'd1, "R10 div512");
    step(1);
    expect_item(0, 32'd2, "R10 div512");
    wr(32'h0);
    wr(mk(1, 0, 0, 0, 12'd0, 0, 0, 2'd0, 1, 1, 10'd0));
    step(16383);
    expect_item(0, 32'd0, "R10 both");
    step(1);
    expect_item(0, 32'd1, "R10 both");

    // periodic timer
    wr(32'h0);
    wr(mk(1, 0, 0, 0, 12'd0, 1, 1, 2'd0, 0, 0, 10'd5));
    step(4);
    expect_item(2, 32'b00, "R11 before period");
    step(1);
    expect_item(2, 32'b10, "R11 period");
    expect_item(3, 32'b10, "R6 api irq");
    api_clr = 1'b1;
    step(1);
    api_clr = 1'b0;
    expect_item(2, 32'b00, "R7 api clear");
    step(3);
    expect_item(2, 32'b00, "R11 mid period");
    step(1);
    expect_item(2, 32'b10, "R11 repeat");
    wr(32'h0);
    wr(mk(1, 0, 0, 0, 12'd0, 1, 1, 2'd0, 0, 0, 10'd0));
    step(30);
    expect_item(2, 32'b00, "R11 zero period");

    // wrap event
    wr(32'h0);
    wr(mk(1, 0, 0, 1, 12'd0, 0, 0, 2'd0, 0, 0, 10'd0));
    step(65535);
    expect_item(0, 32'hFFFF, "R12 all ones");
    expect_item(2, 32'b00, "R12 before wrap");
    step(1);
    expect_item(0, 32'd0, "R12 wrapped");
    expect_item(2, 32'b01, "R12 wrap flag");

    step(2);
    done = 1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule